// File: doc/BRIEF.md
# Transmit/Receive Descriptor Ring Engine

This block runs the two descriptor rings of an Ethernet MAC. Each ring is a circular list of 8-byte descriptors kept in system memory and reached through one shared word-wide memory port. A descriptor holds a 16-bit status, a 16-bit length and a 32-bit buffer pointer. One bit in each status word says who owns the descriptor. On the transmit side, software hands a descriptor over by setting its ready bit. The engine sends the frame to a MAC stub and then clears the ready bit. On the receive side, software hands a descriptor over by setting its empty bit. The engine fills it from the MAC stub, writes back the length and error flags, and clears the empty bit.

A wrap bit marks the last descriptor, and after it each ring returns to its base address. When the engine runs out of descriptors it halts itself. It stays halted until software pulses a clear-halt input. A graceful-stop request on either side lets any frame in progress finish first, and then reports that the side is stopped. Transmit and receive take turns on the memory port, with a fair arbitration between them.

Top module: `bd_ring_engine`

## Requirements
- R1: Descriptor word 0 (byte offset 0) holds status in bits 31:16 and length in bits 15:0, and word 1 (offset 4) holds the buffer pointer. Descriptors lie 8 bytes apart. The low 3 bits of a written base address are ignored.
- R2: In transmit, the engine reads the descriptor at the current address. If the ready bit (word-0 bit 31) is set, it raises `tx_frm_req_o` with the descriptor's pointer and length. It holds these, unchanged, until `tx_frm_done_i`.
- R3: After `tx_frm_done_i`, the engine writes word 0 back with bit 31 cleared and every other status bit and the length unchanged. It then moves to the next descriptor, 8 bytes further on.
- R4: On both rings, a descriptor whose wrap bit (word-0 bit 29) is set is followed by the descriptor at the ring base address.
- R5: If the transmit descriptor read has bit 31 clear, `tx_halted_o` rises. No transmit memory access follows until a `tx_clr_halt_i` pulse. After that pulse the same descriptor is read again.
- R6: For a pending receive frame, the engine reads the descriptor. If the empty bit (word-0 bit 31) is set, it reads the pointer, shows it on `rx_frm_ptr_o`, and pulses `rx_frm_ack_o`. It writes word 0 as follows: bit 31 cleared, bit 29 kept, bit 18 = `rx_frm_err_i[0]` (CRC error), bit 21 = `rx_frm_err_i[1]` (oversize), and the length field = `rx_frm_len_i`, stored unchanged with the 4-byte FCS included.
- R7: If the receive descriptor read has bit 31 clear, `rx_busy_o` and `rx_halted_o` are set and the frame is not acknowledged. `rx_busy_o` stays set until a `busy_clr_i` pulse. Receive restarts only on a `rx_clr_halt_i` pulse, and it then reads the same descriptor again.
- R8: Writing a base address moves that ring's current descriptor to the new base.
- R9: While `tx_stop_i` is high, no new transmit frame starts. `tx_stopped_o` is high exactly when no transmit frame is in progress, so a frame already in progress finishes first.
- R10: While `rx_stop_i` is high, no new receive frame starts. `rx_stopped_o` is high once no receive frame is in progress.
- R11: The memory port carries one word per cycle. A request keeps its address, direction and write data until `mem_ready_i`. Read data is taken in the cycle where both `mem_req_o` and `mem_ready_i` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_base_we_i | input | 1 | Load transmit ring base |
| tx_base_i | input | 32 | Transmit ring base address |
| rx_base_we_i | input | 1 | Load receive ring base |
| rx_base_i | input | 32 | Receive ring base address |
| tx_clr_halt_i | input | 1 | Clear transmit halt (pulse) |
| rx_clr_halt_i | input | 1 | Clear receive halt (pulse) |
| tx_stop_i | input | 1 | Graceful transmit stop request |
| rx_stop_i | input | 1 | Graceful receive stop request |
| busy_clr_i | input | 1 | Write-1-to-clear for the busy event |
| tx_halted_o | output | 1 | Transmit halted |
| rx_halted_o | output | 1 | Receive halted |
| tx_stopped_o | output | 1 | Graceful transmit stop complete |
| rx_stopped_o | output | 1 | Graceful receive stop complete |
| rx_busy_o | output | 1 | No-empty-descriptor event |
| tx_frm_req_o | output | 1 | Frame request to transmit MAC stub |
| tx_frm_ptr_o | output | 32 | Transmit buffer pointer |
| tx_frm_len_o | output | 16 | Transmit frame length |
| tx_frm_done_i | input | 1 | Transmit frame finished |
| rx_frm_valid_i | input | 1 | Receive frame pending |
| rx_frm_len_i | input | 16 | Receive length including FCS |
| rx_frm_err_i | input | 2 | Receive errors: [0] CRC, [1] oversize |
| rx_frm_ack_o | output | 1 | Receive frame stored |
| rx_frm_ptr_o | output | 32 | Receive buffer pointer |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_ready_i | input | 1 | Memory accepts the access |
| mem_rdata_i | input | 32 | Memory read data |

## Verification
The assertions watch several things on every cycle. They check that the memory request and the transmit frame request stay stable while stalled. They check that at most one ring is served per cycle, and that a halted ring makes no access until its clear pulse. They check that a busy event always comes with a receive halt, and that a stopped side starts nothing on the next cycle. Only the bench scenarios can show the data-dependent results. These are the written-back status words and lengths, the order of addresses around a wrapped ring, the re-poll of the same descriptor after a halt is cleared, the effect of a base-address load, and correct behaviour when memory stalls on alternate cycles.

// File: rtl/bdr_pkg.sv
package bdr_pkg;
  localparam int DW         = 32;
  localparam int HW         = DW / 2;
  localparam int DESC_BYTES = 8;
  localparam int PTR_OFF    = 4;
  // status-halfword bit positions
  localparam int ST_OWN     = 15;
  localparam int ST_WRAP    = 13;
  localparam int ST_RX_CRC  = 2;
  localparam int ST_RX_OVR  = 5;

  typedef enum logic [2:0] {TX_IDLE, TX_RD0, TX_RD1, TX_SEND, TX_WB, TX_HALT} tx_st_e;
  typedef enum logic [2:0] {RX_IDLE, RX_RD0, RX_RD1, RX_WB, RX_HALT} rx_st_e;
endpackage

// File: rtl/bdr_mem_arb.sv
module bdr_mem_arb #(
  parameter int NP = 2,
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NP-1:0]          req_i,
  input  logic [NP-1:0]          we_i,
  input  logic [NP-1:0][AW-1:0]  addr_i,
  input  logic [NP-1:0][DW-1:0]  wdata_i,
  output logic [NP-1:0]          ack_o,
  output logic                   mem_req_o,
  output logic                   mem_we_o,
  output logic [AW-1:0]          mem_addr_o,
  output logic [DW-1:0]          mem_wdata_o,
  input  logic                   mem_ready_i
);
  localparam int SW = (NP > 1) ? $clog2(NP) : 1;

  logic          pend_q;
  logic [SW-1:0] own_q, last_q, sel;

  // lock onto a stalled requester, otherwise rotate after the last winner
  always_comb begin
    sel = own_q;
    if (!pend_q) begin
      sel = last_q;
      for (int k = NP; k >= 1; k--) begin
        if (req_i[(int'(last_q) + k) % NP]) sel = SW'((int'(last_q) + k) % NP);
      end
    end
  end

  assign mem_req_o   = req_i[sel];
  assign mem_we_o    = we_i[sel];
  assign mem_addr_o  = addr_i[sel];
  assign mem_wdata_o = wdata_i[sel];

  for (genvar g = 0; g < NP; g++) begin : g_ack
    assign ack_o[g] = (sel == SW'(g)) && req_i[g] && mem_ready_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      own_q  <= '0;
      last_q <= '0;
    end else begin
      pend_q <= mem_req_o && !mem_ready_i;
      own_q  <= sel;
      if (mem_req_o && mem_ready_i) last_q <= sel;
    end
  end

  assert_one_grant_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ack_o));
  assert_req_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));
endmodule

// File: rtl/bdr_tx_eng.sv
module bdr_tx_eng
  import bdr_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          base_we_i,
  input  logic [AW-1:0] base_i,
  input  logic          clr_halt_i,
  input  logic          stop_i,
  output logic          stop_done_o,
  output logic          halt_o,
  output logic          frm_req_o,
  output logic [DW-1:0] frm_ptr_o,
  output logic [HW-1:0] frm_len_o,
  input  logic          frm_done_i,
  output logic          mreq_o,
  output logic          mwe_o,
  output logic [AW-1:0] maddr_o,
  output logic [DW-1:0] mwdata_o,
  input  logic          mack_i,
  input  logic [DW-1:0] mrdata_i
);
  localparam logic [AW-1:0] ALIGN = ~AW'(DESC_BYTES - 1);

  tx_st_e        st_q;
  logic [AW-1:0] base_q, cur_q, nxt;
  logic [HW-1:0] stat_q, len_q;
  logic [DW-1:0] ptr_q;

  assign nxt       = stat_q[ST_WRAP] ? base_q : cur_q + AW'(DESC_BYTES);
  assign mreq_o    = (st_q == TX_RD0) || (st_q == TX_RD1) || (st_q == TX_WB);
  assign mwe_o     = (st_q == TX_WB);
  assign maddr_o   = (st_q == TX_RD1) ? cur_q + AW'(PTR_OFF) : cur_q;
  assign mwdata_o  = {stat_q & ~(HW'(1) << ST_OWN), len_q};
  assign frm_req_o = (st_q == TX_SEND);
  assign frm_ptr_o = ptr_q;
  assign frm_len_o = len_q;
  assign halt_o    = (st_q == TX_HALT);
  assign stop_done_o = stop_i && ((st_q == TX_IDLE) || (st_q == TX_HALT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= TX_IDLE;
      base_q <= '0;
      cur_q  <= '0;
      stat_q <= '0;
      len_q  <= '0;
      ptr_q  <= '0;
    end else begin
      unique case (st_q)
        TX_IDLE: if (!stop_i) st_q <= TX_RD0;
        TX_RD0: if (mack_i) begin
          stat_q <= mrdata_i[DW-1:HW];
          len_q  <= mrdata_i[HW-1:0];
          st_q   <= mrdata_i[HW+ST_OWN] ? TX_RD1 : TX_HALT;
        end
        TX_RD1: if (mack_i) begin
          ptr_q <= mrdata_i;
          st_q  <= TX_SEND;
        end
        TX_SEND: if (frm_done_i) st_q <= TX_WB;
        TX_WB: if (mack_i) begin
          cur_q <= nxt;
          st_q  <= TX_IDLE;
        end
        TX_HALT: if (clr_halt_i) st_q <= TX_IDLE;
        default: st_q <= TX_IDLE;
      endcase
      if (base_we_i) begin
        base_q <= base_i & ALIGN;
        cur_q  <= base_i & ALIGN;
      end
    end
  end

  assert_frm_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_req_o && !frm_done_i |=> frm_req_o && $stable(frm_ptr_o) && $stable(frm_len_o));
  assert_halt_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o && !clr_halt_i |=> !mreq_o);
  assert_stop_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_done_o |=> !mreq_o && !frm_req_o);
endmodule

// File: rtl/bdr_rx_eng.sv
module bdr_rx_eng
  import bdr_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          base_we_i,
  input  logic [AW-1:0] base_i,
  input  logic          clr_halt_i,
  input  logic          stop_i,
  output logic          stop_done_o,
  output logic          halt_o,
  output logic          busy_o,
  input  logic          busy_clr_i,
  input  logic          frm_valid_i,
  input  logic [HW-1:0] frm_len_i,
  input  logic [1:0]    frm_err_i,
  output logic          frm_ack_o,
  output logic [DW-1:0] frm_ptr_o,
  output logic          mreq_o,
  output logic          mwe_o,
  output logic [AW-1:0] maddr_o,
  output logic [DW-1:0] mwdata_o,
  input  logic          mack_i,
  input  logic [DW-1:0] mrdata_i
);
  localparam logic [AW-1:0] ALIGN = ~AW'(DESC_BYTES - 1);

  rx_st_e        st_q;
  logic [AW-1:0] base_q, cur_q;
  logic          wrap_q, busy_q;
  logic [DW-1:0] ptr_q;
  logic [HW-1:0] wb_stat;

  always_comb begin
    wb_stat            = '0;
    wb_stat[ST_WRAP]   = wrap_q;
    wb_stat[ST_RX_CRC] = frm_err_i[0];
    wb_stat[ST_RX_OVR] = frm_err_i[1];
  end

  assign mreq_o      = (st_q == RX_RD0) || (st_q == RX_RD1) || (st_q == RX_WB);
  assign mwe_o       = (st_q == RX_WB);
  assign maddr_o     = (st_q == RX_RD1) ? cur_q + AW'(PTR_OFF) : cur_q;
  assign mwdata_o    = {wb_stat, frm_len_i};
  assign frm_ack_o   = (st_q == RX_WB) && mack_i;
  assign frm_ptr_o   = ptr_q;
  assign halt_o      = (st_q == RX_HALT);
  assign busy_o      = busy_q;
  assign stop_done_o = stop_i && ((st_q == RX_IDLE) || (st_q == RX_HALT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= RX_IDLE;
      base_q <= '0;
      cur_q  <= '0;
      wrap_q <= 1'b0;
      busy_q <= 1'b0;
      ptr_q  <= '0;
    end else begin
      if (busy_clr_i) busy_q <= 1'b0;
      unique case (st_q)
        RX_IDLE: if (frm_valid_i && !stop_i) st_q <= RX_RD0;
        RX_RD0: if (mack_i) begin
          wrap_q <= mrdata_i[HW+ST_WRAP];
          if (mrdata_i[HW+ST_OWN]) st_q <= RX_RD1;
          else begin
            st_q   <= RX_HALT;
            busy_q <= 1'b1;
          end
        end
        RX_RD1: if (mack_i) begin
          ptr_q <= mrdata_i;
          st_q  <= RX_WB;
        end
        RX_WB: if (mack_i) begin
          cur_q <= wrap_q ? base_q : cur_q + AW'(DESC_BYTES);
          st_q  <= RX_IDLE;
        end
        RX_HALT: if (clr_halt_i) st_q <= RX_IDLE;
        default: st_q <= RX_IDLE;
      endcase
      if (base_we_i) begin
        base_q <= base_i & ALIGN;
        cur_q  <= base_i & ALIGN;
      end
    end
  end

  assert_busy_halts_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> halt_o);
  assert_halt_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o && !clr_halt_i |=> halt_o && !frm_ack_o && !mreq_o);
  assert_stop_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_done_o |=> !mreq_o);
endmodule

// File: rtl/bd_ring_engine.sv
module bd_ring_engine
  import bdr_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tx_base_we_i,
  input  logic [AW-1:0] tx_base_i,
  input  logic          rx_base_we_i,
  input  logic [AW-1:0] rx_base_i,
  input  logic          tx_clr_halt_i,
  input  logic          rx_clr_halt_i,
  input  logic          tx_stop_i,
  input  logic          rx_stop_i,
  input  logic          busy_clr_i,
  output logic          tx_halted_o,
  output logic          rx_halted_o,
  output logic          tx_stopped_o,
  output logic          rx_stopped_o,
  output logic          rx_busy_o,
  output logic          tx_frm_req_o,
  output logic [DW-1:0] tx_frm_ptr_o,
  output logic [HW-1:0] tx_frm_len_o,
  input  logic          tx_frm_done_i,
  input  logic          rx_frm_valid_i,
  input  logic [HW-1:0] rx_frm_len_i,
  input  logic [1:0]    rx_frm_err_i,
  output logic          rx_frm_ack_o,
  output logic [DW-1:0] rx_frm_ptr_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_ready_i,
  input  logic [DW-1:0] mem_rdata_i
);
  localparam int NP = 2;  // port 0 transmit, port 1 receive

  logic [NP-1:0]         p_req, p_we, p_ack;
  logic [NP-1:0][AW-1:0] p_addr;
  logic [NP-1:0][DW-1:0] p_wdata;

  bdr_tx_eng #(.AW(AW)) u_tx (
    .clk_i, .rst_ni,
    .base_we_i(tx_base_we_i), .base_i(tx_base_i),
    .clr_halt_i(tx_clr_halt_i), .stop_i(tx_stop_i),
    .stop_done_o(tx_stopped_o), .halt_o(tx_halted_o),
    .frm_req_o(tx_frm_req_o), .frm_ptr_o(tx_frm_ptr_o), .frm_len_o(tx_frm_len_o),
    .frm_done_i(tx_frm_done_i),
    .mreq_o(p_req[0]), .mwe_o(p_we[0]), .maddr_o(p_addr[0]), .mwdata_o(p_wdata[0]),
    .mack_i(p_ack[0]), .mrdata_i(mem_rdata_i)
  );

  bdr_rx_eng #(.AW(AW)) u_rx (
    .clk_i, .rst_ni,
    .base_we_i(rx_base_we_i), .base_i(rx_base_i),
    .clr_halt_i(rx_clr_halt_i), .stop_i(rx_stop_i),
    .stop_done_o(rx_stopped_o), .halt_o(rx_halted_o),
    .busy_o(rx_busy_o), .busy_clr_i(busy_clr_i),
    .frm_valid_i(rx_frm_valid_i), .frm_len_i(rx_frm_len_i), .frm_err_i(rx_frm_err_i),
    .frm_ack_o(rx_frm_ack_o), .frm_ptr_o(rx_frm_ptr_o),
    .mreq_o(p_req[1]), .mwe_o(p_we[1]), .maddr_o(p_addr[1]), .mwdata_o(p_wdata[1]),
    .mack_i(p_ack[1]), .mrdata_i(mem_rdata_i)
  );

  bdr_mem_arb #(.NP(NP), .AW(AW), .DW(DW)) u_arb (
    .clk_i, .rst_ni,
    .req_i(p_req), .we_i(p_we), .addr_i(p_addr), .wdata_i(p_wdata), .ack_o(p_ack),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_ready_i
  );
endmodule

// File: tb/bd_ring_engine_bench.sv
module bd_ring_engine_bench;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic        tx_base_we_i = 0, rx_base_we_i = 0;
  logic [31:0] tx_base_i = 0, rx_base_i = 0;
  logic        tx_clr_halt_i = 0, rx_clr_halt_i = 0, tx_stop_i = 0, rx_stop_i = 0, busy_clr_i = 0;
  logic        tx_halted_o, rx_halted_o, tx_stopped_o, rx_stopped_o, rx_busy_o;
  logic        tx_frm_req_o, tx_frm_done_i;
  logic [31:0] tx_frm_ptr_o;
  logic [15:0] tx_frm_len_o;
  logic        rx_frm_valid_i = 0;
  logic [15:0] rx_frm_len_i = 0;
  logic [1:0]  rx_frm_err_i = 0;
  logic        rx_frm_ack_o;
  logic [31:0] rx_frm_ptr_o;
  logic        mem_req_o, mem_we_o, mem_ready_i;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i;

  bd_ring_engine u_bd_ring_engine (.clk_i(clk), .*);

  // memory model: 64 words, one writer process
  logic [31:0] mem [64];
  logic        poke_en = 0;
  logic [31:0] poke_addr = 0, poke_data = 0;
  logic [31:0] last_rd_addr;
  int          rd_cnt;
  assign mem_rdata_i = mem[mem_addr_o[7:2]];

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < 64; i++) mem[i] <= '0;
      last_rd_addr <= '0;
      rd_cnt <= 0;
    end else begin
      if (mem_req_o && mem_ready_i && mem_we_o) mem[mem_addr_o[7:2]] <= mem_wdata_o;
      if (mem_req_o && mem_ready_i && !mem_we_o) begin
        last_rd_addr <= mem_addr_o;
        rd_cnt <= rd_cnt + 1;
      end
      if (poke_en) mem[poke_addr[7:2]] <= poke_data;
    end
  end

  int n_tests = 0, n_fail = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic poke(input logic [31:0] a, input logic [31:0] d);
    poke_addr = a; poke_data = d; poke_en = 1;
    tick();
    poke_en = 0;
  endtask

  // transmit MAC stub: finishes each frame after 4 cycles of request
  int          hold = 0, tx_frames = 0;
  logic [31:0] cap_ptr = 0;
  logic [15:0] cap_len = 0;
  initial begin
    tx_frm_done_i = 0;
    forever begin
      @(negedge clk);
      if (tx_frm_done_i) tx_frm_done_i = 0;
      else if (tx_frm_req_o) begin
        hold++;
        if (hold == 4) begin
          tx_frm_done_i = 1; hold = 0;
          cap_ptr = tx_frm_ptr_o; cap_len = tx_frm_len_o; tx_frames++;
        end
      end
    end
  end

  // memory stall generator and stall-hold monitor
  logic        stall_en = 0, tgl = 0;
  logic        s_req = 0, s_we = 0, s_rdy = 1;
  logic [31:0] s_addr = 0, s_wd = 0;
  int          hold_viol = 0;
  initial begin
    mem_ready_i = 1;
    forever begin
      @(negedge clk);
      if (s_req && !s_rdy &&
          (!mem_req_o || mem_addr_o != s_addr || mem_we_o != s_we || (s_we && mem_wdata_o != s_wd)))
        hold_viol++;
      s_req = mem_req_o; s_we = mem_we_o; s_addr = mem_addr_o; s_wd = mem_wdata_o;
      tgl = ~tgl;
      mem_ready_i = !(stall_en && tgl);
      s_rdy = mem_ready_i;
    end
  end

  task automatic wait_txhalt();
    for (int i = 0; i < 300; i++) begin
      tick();
      if (tx_halted_o) break;
    end
  endtask

  logic [31:0] rx_ptr_cap;
  task automatic rx_wait_ack(output logic got);
    got = 0;
    for (int i = 0; i < 300; i++) begin
      tick();
      if (rx_frm_ack_o) begin
        rx_ptr_cap = rx_frm_ptr_o; rx_frm_valid_i = 0; got = 1;
        break;
      end
    end
    tick();
  endtask

  task automatic rx_start(input logic [15:0] len, input logic [1:0] err);
    rx_frm_len_i = len; rx_frm_err_i = err; rx_frm_valid_i = 1;
  endtask

  typedef struct packed {
    logic [31:0] addr;
    logic [31:0] ptr;
    logic [15:0] len;
    logic        wrap;
    logic [31:0] nxt;
  } txv_t;

  localparam txv_t TXV [4] = '{
    '{32'h00, 32'h1000_0100, 16'd64,   1'b0, 32'h08},
    '{32'h08, 32'h2000_0200, 16'd1518, 1'b0, 32'h10},
    '{32'h10, 32'h3000_0300, 16'd60,   1'b1, 32'h00},
    '{32'h00, 32'h4000_0400, 16'd128,  1'b0, 32'h08}
  };

  initial begin
    logic got;
    int   base_rd, base_fr, acks;
    repeat (3) tick();
    chk("R5 reset tx_halted_o", 32'(tx_halted_o), 0);
    chk("R7 reset rx_busy_o", 32'(rx_busy_o), 0);
    chk("R2 reset tx_frm_req_o", 32'(tx_frm_req_o), 0);
    chk("R11 reset mem_req_o", 32'(mem_req_o), 0);
    rst_ni = 1;
    wait_txhalt();
    chk("R5 empty ring halts tx", 32'(tx_halted_o), 1);
    tx_base_i = 32'h0; tx_base_we_i = 1; tick(); tx_base_we_i = 0;

    // R2 R3 R4: table of transmit descriptors around a wrapped ring
    foreach (TXV[k]) begin
      poke(TXV[k].addr, {16'h9C00 | (16'(TXV[k].wrap) << 13), TXV[k].len});
      poke(TXV[k].addr + 4, TXV[k].ptr);
      tx_clr_halt_i = 1; tick(); tx_clr_halt_i = 0;
      wait_txhalt();
      chk("R2 tx pointer", cap_ptr, TXV[k].ptr);
      chk("R2 tx length", 32'(cap_len), 32'(TXV[k].len));
      chk("R3 tx writeback", mem[TXV[k].addr[7:2]], {16'h1C00 | (16'(TXV[k].wrap) << 13), TXV[k].len});
      chk("R4 R3 next descriptor", last_rd_addr, TXV[k].nxt);
    end

    // R5: halted tx stays quiet, then re-polls the same descriptor
    base_rd = rd_cnt;
    repeat (20) tick();
    chk("R5 no reads while halted", 32'(rd_cnt), 32'(base_rd));
    tx_clr_halt_i = 1; tick(); tx_clr_halt_i = 0;
    wait_txhalt();
    chk("R5 repoll count", 32'(rd_cnt), 32'(base_rd + 1));
    chk("R5 repoll address", last_rd_addr, 32'h08);

    // R8 R1: base load with unaligned low bits
    poke(32'h40, {16'hBC00, 16'd200});
    poke(32'h44, 32'h5000_0500);
    tx_base_i = 32'h43; tx_base_we_i = 1; tick(); tx_base_we_i = 0;
    tx_clr_halt_i = 1; tick(); tx_clr_halt_i = 0;
    wait_txhalt();
    chk("R8 R1 frame from new base", cap_ptr, 32'h5000_0500);
    chk("R4 wrap returns to base", last_rd_addr, 32'h40);
    chk("R1 writeback at base", mem[16], {16'h3C00, 16'd200});

    // R9: graceful transmit stop
    tx_stop_i = 1; tick();
    chk("R9 stopped while halted", 32'(tx_stopped_o), 1);
    poke(32'h40, {16'hBC00, 16'd300});
    base_fr = tx_frames;
    tx_clr_halt_i = 1; tick(); tx_clr_halt_i = 0;
    repeat (20) tick();
    chk("R9 no frame while stopped", 32'(tx_frames), 32'(base_fr));
    tx_stop_i = 0;
    for (int i = 0; i < 50; i++) begin tick(); if (tx_frm_req_o) break; end
    tx_stop_i = 1; tick();
    chk("R9 not stopped mid-frame", 32'(tx_stopped_o), 0);
    for (int i = 0; i < 50; i++) begin tick(); if (tx_stopped_o) break; end
    chk("R9 frame finished before stop", mem[16], {16'h3C00, 16'd300});
    tx_stop_i = 0;
    wait_txhalt();

    // R6: receive into two descriptors, second one wraps
    rx_base_i = 32'h80; rx_base_we_i = 1; tick(); rx_base_we_i = 0;
    poke(32'h80, {16'h8000, 16'd0});
    poke(32'h84, 32'hA000_0000);
    poke(32'h88, {16'hA000, 16'd0});
    poke(32'h8C, 32'hA000_1000);
    rx_start(16'd68, 2'b00); rx_wait_ack(got);
    chk("R6 rx ack", 32'(got), 1);
    chk("R6 rx pointer", rx_ptr_cap, 32'hA000_0000);
    chk("R6 rx writeback", mem[32], {16'h0000, 16'd68});
    rx_start(16'd1522, 2'b01); rx_wait_ack(got);
    chk("R6 rx pointer 2", rx_ptr_cap, 32'hA000_1000);
    chk("R6 R4 rx crc err with wrap", mem[34], {16'h2004, 16'd1522});

    // R7: no empty descriptor
    rx_start(16'd100, 2'b10);
    acks = 0;
    for (int i = 0; i < 20; i++) begin tick(); if (rx_frm_ack_o) acks++; end
    chk("R7 no ack when full", 32'(acks), 0);
    chk("R7 busy set", 32'(rx_busy_o), 1);
    chk("R7 rx halted", 32'(rx_halted_o), 1);
    busy_clr_i = 1; tick(); busy_clr_i = 0;
    chk("R7 busy cleared", 32'(rx_busy_o), 0);
    chk("R7 still halted", 32'(rx_halted_o), 1);
    poke(32'h80, {16'h8000, 16'd0});
    rx_clr_halt_i = 1; tick(); rx_clr_halt_i = 0;
    rx_wait_ack(got);
    chk("R7 resume same descriptor", rx_ptr_cap, 32'hA000_0000);
    chk("R6 oversize flag", mem[32], {16'h0020, 16'd100});

    // R10: graceful receive stop
    rx_stop_i = 1; tick();
    chk("R10 rx stopped", 32'(rx_stopped_o), 1);
    poke(32'h88, {16'hA000, 16'd0});
    rx_start(16'd64, 2'b00);
    acks = 0;
    for (int i = 0; i < 20; i++) begin tick(); if (rx_frm_ack_o) acks++; end
    chk("R10 no rx while stopped", 32'(acks), 0);
    rx_stop_i = 0;
    rx_wait_ack(got);
    chk("R10 rx after release", mem[34], {16'h2000, 16'd64});

    // R11: memory stalls on alternate cycles
    stall_en = 1;
    poke(32'h80, {16'h8000, 16'd0});
    rx_start(16'd512, 2'b11); rx_wait_ack(got);
    chk("R11 rx under stall ptr", rx_ptr_cap, 32'hA000_0000);
    chk("R11 rx under stall data", mem[32], {16'h0024, 16'd512});
    stall_en = 0;
    chk("R11 request held while stalled", 32'(hold_viol), 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL R11 watchdog act=running exp=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule